// File: doc/BRIEF.md
# Ethernet MAC Network Control and Status Registers

This block holds the two byte-wide registers that software uses to steer an Ethernet MAC and to learn what it has done. The control byte at offset 0x00 selects the loopback path, forces collisions for test, picks an internal or external PHY, arms wake detection, sets full duplex when an external PHY is in use, and launches a self-timed soft reset. The status byte at offset 0x01 reports live levels: link, speed, receive data pending and transmit memory full. It also holds sticky event flags for the two transmit slots, receive overflow and wake.

Register access is a plain strobe bus. Read data is combinational from the address. A read strobe to the status address clears the sticky flags after the value has been returned. A write to the status address clears each sticky flag whose data bit is 1. The soft reset holds the soft-resettable state at its defaults for a fixed interval, counted in clock cycles and derived from the clock frequency. The PHY selection, the wake enable and the wake flag are kept through a soft reset.

Top module: `netctl_regs`

## Requirements
- R1: After hardware reset, every control output is 0, and both registers read 0 when all level inputs are 0.
- R2: Control bit positions: 6 external PHY select, 5 wake enable, 3 force collision, 2:1 loopback mode (00 normal, 01 MAC loopback, 10 PHY digital, 11 PHY analog). A write drives these fields to the outputs, and they read back at the same positions.
- R3: Writing 1 to control bit 0 asserts `soft_rst` for exactly CLK_HZ/1e6 × SRST_US cycles (500 by default). Bit 0 reads back `soft_rst`. Writing it again while active does not extend the interval.
- R4: While the soft reset is active, and in the write that starts it, loopback, force collision, the duplex register and the three transmit/overflow sticky flags are held at 0 and ignore writes and events. External PHY select, wake enable and the wake flag are kept.
- R5: Status bits 1, 2 and 0 are set by `tx1_done`, `tx2_done` and `rx_ovf` pulses and stay set until cleared.
- R6: A read strobe to status clears all sticky flags (bits 0, 1, 2, 5) after returning them. An event in the same cycle wins and leaves its flag set.
- R7: A status write clears each sticky flag whose data bit is 1 and leaves the others. An event in the same cycle wins.
- R8: The wake flag (status bit 5) is set by `wake_evt` only while wake enable is 1. A control write with bit 5 = 0 clears it.
- R9: Status bit 3 reads 1 when `tx_slots` ≥ 2, bit 4 reads `rx_pending`, bit 6 reads `link_up` and bit 7 reads `speed_10m` (1 = 10 Mbps).
- R10: Control bit 7 and `fdx` follow `fdx_in` while the internal PHY is selected, and writes to bit 7 are then ignored. With the external PHY selected, bit 7 is a writable register that drives `fdx`.
- R11: Control bit 4 reads 0 and ignores writes. Addresses other than 0x00 and 0x01 read 0 and their writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| tx1_done | input | 1 | Transmit slot 1 complete pulse |
| tx2_done | input | 1 | Transmit slot 2 complete pulse |
| tx_slots | input | 2 | Number of occupied transmit slots |
| rx_pending | input | 1 | Received packets present |
| rx_ovf | input | 1 | Receive overflow pulse |
| wake_evt | input | 1 | Wake event pulse |
| link_up | input | 1 | Link status |
| speed_10m | input | 1 | 1 = 10 Mbps, 0 = 100 Mbps |
| fdx_in | input | 1 | Duplex reported by the internal PHY |
| soft_rst | output | 1 | Soft reset in progress |
| lpbk_mode | output | 2 | Loopback selection |
| fdx | output | 1 | Effective full duplex |
| force_col | output | 1 | Force collision |
| ext_phy_sel | output | 1 | External PHY selected |
| wake_en | output | 1 | Wake detection armed |

## Verification
The assertions check on every cycle that the soft reset starts after its write and lasts exactly its programmed length. They also check that the held fields stay at zero throughout it, that a read or a wake-enable clear empties the flags it should, that an event sets its flag, and that the duplex output and the full flag follow their inputs. Only the bench scenarios can show that an event coinciding with a clear survives, that a re-trigger does not lengthen the reset, and that the exempt bits come out of a soft reset unchanged. The same goes for the per-bit selectivity of write-1 clearing and the full sweep of field positions and level inputs.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
  // control byte bit positions
  localparam int C_SRST    = 0;
  localparam int C_LB_LO   = 1;
  localparam int C_FCOL    = 3;
  localparam int C_RSVD    = 4;
  localparam int C_WAKE_EN = 5;
  localparam int C_EXT     = 6;
  localparam int C_FDX     = 7;
  // status byte bit positions
  localparam int S_RXOV    = 0;
  localparam int S_TX1     = 1;
  localparam int S_TX2     = 2;
  localparam int S_TXFULL  = 3;
  localparam int S_RXRDY   = 4;
  localparam int S_WAKE    = 5;
  localparam int S_LINK    = 6;
  localparam int S_SPEED   = 7;

  typedef enum logic [1:0] {
    LB_NONE    = 2'b00,
    LB_MAC     = 2'b01,
    LB_PHY_DIG = 2'b10,
    LB_PHY_ANA = 2'b11
  } lb_mode_e;

  function automatic int unsigned srst_cycles(int unsigned hz, int unsigned us);
    int unsigned c;
    c = (hz / 1000000) * us;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/nc_srst_timer.sv
module nc_srst_timer #(
  parameter int unsigned CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q, busy_n;

  always_comb begin
    cnt_n  = cnt_q;
    busy_n = busy_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - 1'b1;
    end else if (start) begin
      busy_n = 1'b1;
      cnt_n  = CNT_W'(CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/nc_ctrl_reg.sv
module nc_ctrl_reg
  import netctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       hold,
  input  logic [1:0] w_lpbk,
  input  logic       w_fcol,
  input  logic       w_wake,
  input  logic       w_ext,
  input  logic       w_fdx,
  input  logic       fdx_in,
  output logic [1:0] lpbk,
  output logic       fcol,
  output logic       wake_en,
  output logic       ext,
  output logic       fdx_eff,
  output logic       wake_clr
);
  lb_mode_e lb_q, lb_n;
  logic fcol_q, fcol_n, fdx_q, fdx_n, ext_q, ext_n, wake_q, wake_n;

  always_comb begin
    lb_n   = lb_q;
    fcol_n = fcol_q;
    fdx_n  = fdx_q;
    ext_n  = wr_en ? w_ext  : ext_q;
    wake_n = wr_en ? w_wake : wake_q;
    if (hold) begin
      lb_n   = LB_NONE;
      fcol_n = 1'b0;
      fdx_n  = 1'b0;
    end else if (wr_en) begin
      lb_n   = lb_mode_e'(w_lpbk);
      fcol_n = w_fcol;
      if (ext_q) fdx_n = w_fdx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_q   <= LB_NONE;
      fcol_q <= 1'b0;
      fdx_q  <= 1'b0;
      ext_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      lb_q   <= lb_n;
      fcol_q <= fcol_n;
      fdx_q  <= fdx_n;
      ext_q  <= ext_n;
      wake_q <= wake_n;
    end
  end

  assign lpbk     = lb_q;
  assign fcol     = fcol_q;
  assign wake_en  = wake_q;
  assign ext      = ext_q;
  assign fdx_eff  = ext_q ? fdx_q : fdx_in;
  assign wake_clr = wr_en & ~w_wake;
endmodule

// File: rtl/nc_stat_reg.sv
module nc_stat_reg #(
  parameter int N_EV = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          rd_clr,
  input  logic [N_EV:0] w1c,
  input  logic [N_EV-1:0] ev,
  input  logic          wake_ev,
  input  logic          wake_en,
  input  logic          wake_clr,
  output logic [N_EV:0] sticky
);
  logic [N_EV:0] st_q, st_n;

  // soft-resettable event flags
  for (genvar i = 0; i < N_EV; i++) begin : g_ev
    always_comb begin
      if (hold)                  st_n[i] = 1'b0;
      else if (ev[i])            st_n[i] = 1'b1;
      else if (rd_clr || w1c[i]) st_n[i] = 1'b0;
      else                       st_n[i] = st_q[i];
    end
  end

  // wake flag: kept through soft reset, cleared with wake enable
  always_comb begin
    if (wake_clr)                    st_n[N_EV] = 1'b0;
    else if (wake_ev && wake_en)     st_n[N_EV] = 1'b1;
    else if (rd_clr || w1c[N_EV])    st_n[N_EV] = 1'b0;
    else                             st_n[N_EV] = st_q[N_EV];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_n;
  end

  assign sticky = st_q;
endmodule

// File: rtl/netctl_regs.sv
module netctl_regs
  import netctl_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SRST_US   = 10,
  parameter int          ADDR_W    = 8,
  parameter int          CTRL_ADDR = 0,
  parameter int          STAT_ADDR = 1,
  parameter int          TX_DEPTH  = 2,
  localparam int         SLOT_W    = $clog2(TX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tx1_done,
  input  logic              tx2_done,
  input  logic [SLOT_W-1:0] tx_slots,
  input  logic              rx_pending,
  input  logic              rx_ovf,
  input  logic              wake_evt,
  input  logic              link_up,
  input  logic              speed_10m,
  input  logic              fdx_in,
  output logic              soft_rst,
  output logic [1:0]        lpbk_mode,
  output logic              fdx,
  output logic              force_col,
  output logic              ext_phy_sel,
  output logic              wake_en
);
  localparam int unsigned SRST_CYC = srst_cycles(CLK_HZ, SRST_US);

  logic       sel_ctrl, sel_stat, ctrl_wr, srst_go, hold, wake_clr;
  logic [3:0] sticky;  // {wake, rxov, tx2, tx1}
  logic [3:0] w1c;
  logic [7:0] ctrl_byte, stat_byte;

  assign sel_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
  assign sel_stat = (bus_addr == ADDR_W'(STAT_ADDR));
  assign ctrl_wr  = bus_wr & sel_ctrl;
  assign srst_go  = ctrl_wr & bus_wdata[C_SRST] & ~soft_rst;
  assign hold     = soft_rst | srst_go;
  assign w1c      = {4{bus_wr & sel_stat}} &
                    {bus_wdata[S_WAKE], bus_wdata[S_RXOV], bus_wdata[S_TX2], bus_wdata[S_TX1]};

  nc_srst_timer #(.CYC(SRST_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(srst_go), .busy(soft_rst)
  );

  nc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .hold(hold),
    .w_lpbk(bus_wdata[C_LB_LO +: 2]), .w_fcol(bus_wdata[C_FCOL]),
    .w_wake(bus_wdata[C_WAKE_EN]), .w_ext(bus_wdata[C_EXT]),
    .w_fdx(bus_wdata[C_FDX]), .fdx_in(fdx_in),
    .lpbk(lpbk_mode), .fcol(force_col), .wake_en(wake_en),
    .ext(ext_phy_sel), .fdx_eff(fdx), .wake_clr(wake_clr)
  );

  nc_stat_reg #(.N_EV(3)) u_stat (
    .clk(clk), .rst_n(rst_n), .hold(hold), .rd_clr(bus_rd & sel_stat),
    .w1c(w1c), .ev({rx_ovf, tx2_done, tx1_done}), .wake_ev(wake_evt),
    .wake_en(wake_en), .wake_clr(wake_clr), .sticky(sticky)
  );

  always_comb begin
    ctrl_byte                 = '0;
    ctrl_byte[C_SRST]         = soft_rst;
    ctrl_byte[C_LB_LO +: 2]   = lpbk_mode;
    ctrl_byte[C_FCOL]         = force_col;
    ctrl_byte[C_RSVD]         = 1'b0;
    ctrl_byte[C_WAKE_EN]      = wake_en;
    ctrl_byte[C_EXT]          = ext_phy_sel;
    ctrl_byte[C_FDX]          = fdx;

    stat_byte                 = '0;
    stat_byte[S_TX1]          = sticky[0];
    stat_byte[S_TX2]          = sticky[1];
    stat_byte[S_RXOV]         = sticky[2];
    stat_byte[S_WAKE]         = sticky[3];
    stat_byte[S_TXFULL]       = (tx_slots >= SLOT_W'(TX_DEPTH));
    stat_byte[S_RXRDY]        = rx_pending;
    stat_byte[S_LINK]         = link_up;
    stat_byte[S_SPEED]        = speed_10m;

    if (sel_ctrl)      bus_rdata = ctrl_byte;
    else if (sel_stat) bus_rdata = stat_byte;
    else               bus_rdata = '0;
  end
endmodule

// File: rtl/nc_checker.sv
module nc_checker #(
  parameter int unsigned SRST_CYC  = 500,
  parameter int          ADDR_W    = 8,
  parameter int          CTRL_ADDR = 0,
  parameter int          STAT_ADDR = 1,
  parameter int          TX_DEPTH  = 2,
  parameter int          SLOT_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              wd_srst,
  input logic              wd_wake,
  input logic              rd_full,
  input logic              rd_rsvd,
  input logic              tx1_done,
  input logic [SLOT_W-1:0] tx_slots,
  input logic              fdx_in,
  input logic              soft_rst,
  input logic [1:0]        lpbk_mode,
  input logic              force_col,
  input logic              ext_phy_sel,
  input logic              wake_en,
  input logic              fdx,
  input logic [3:0]        sticky
);
  logic ctrl_wr, stat_sel, go;
  int unsigned len_q;

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign stat_sel = (bus_addr == ADDR_W'(STAT_ADDR));
  assign go       = ctrl_wr && wd_srst && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= 0;
    else        len_q <= soft_rst ? len_q + 1 : 0;
  end

  a_r3_srst_start: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> soft_rst);
  a_r3_srst_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst) |-> len_q == SRST_CYC);
  a_r3_srst_max: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> len_q < SRST_CYC);
  a_r4_held: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (lpbk_mode == 2'b00 && !force_col && sticky[2:0] == 3'b000));
  a_r4_ext_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ext_phy_sel) && $stable(wake_en));
  a_r5_tx1_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tx1_done && !soft_rst && !go) |=> sticky[0]);
  a_r6_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && stat_sel && !tx1_done) |=> !sticky[0]);
  a_r8_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wd_wake) |=> (!wake_en && !sticky[3]));
  a_r9_txfull: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sel |-> rd_full == (tx_slots >= SLOT_W'(TX_DEPTH)));
  a_r10_fdx_int: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_phy_sel |-> fdx == fdx_in);
  a_r11_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(CTRL_ADDR)) |-> !rd_rsvd);
endmodule

bind netctl_regs nc_checker #(
  .SRST_CYC(SRST_CYC), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
  .STAT_ADDR(STAT_ADDR), .TX_DEPTH(TX_DEPTH), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .wd_srst(bus_wdata[0]), .wd_wake(bus_wdata[5]),
  .rd_full(bus_rdata[3]), .rd_rsvd(bus_rdata[4]),
  .tx1_done(tx1_done), .tx_slots(tx_slots), .fdx_in(fdx_in),
  .soft_rst(soft_rst), .lpbk_mode(lpbk_mode), .force_col(force_col),
  .ext_phy_sel(ext_phy_sel), .wake_en(wake_en), .fdx(fdx), .sticky(sticky)
);

// File: tb/tb_netctl_regs.sv
`timescale 1ns/1ps
module tb_netctl_regs;
  localparam int SRST_LEN = 500;  // 50 MHz x 10 us

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] evs = '0;  // {wake, ovf, tx2, tx1}
  logic [1:0] tx_slots = '0;
  logic       rx_pending = 1'b0, link_up = 1'b0, speed_10m = 1'b0, fdx_in = 1'b0;
  logic       soft_rst, fdx, force_col, ext_phy_sel, wake_en;
  logic [1:0] lpbk_mode;

  int checks = 0, failures = 0, cyc = 0;

  netctl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx1_done(evs[0]), .tx2_done(evs[1]), .tx_slots(tx_slots),
    .rx_pending(rx_pending), .rx_ovf(evs[2]), .wake_evt(evs[3]),
    .link_up(link_up), .speed_10m(speed_10m), .fdx_in(fdx_in),
    .soft_rst(soft_rst), .lpbk_mode(lpbk_mode), .fdx(fdx), .force_col(force_col),
    .ext_phy_sel(ext_phy_sel), .wake_en(wake_en)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(logic [3:0] m);
    evs = m;
    @(posedge clk); @(negedge clk);
    evs = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {soft_rst, lpbk_mode, fdx, force_col, ext_phy_sel, wake_en}, 0);
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h01, v); chk("R1 stat", v, 0);

    // R2 field sweep
    for (int i = 0; i < 32; i++) begin
      logic [7:0] d;
      d = {1'b0, i[4], i[3], 1'b0, i[2], i[1:0], 1'b0};
      wr(8'h00, d);
      chk("R2 lpbk", lpbk_mode, i[1:0]);
      chk("R2 outs", {ext_phy_sel, wake_en, force_col}, i[4:2]);
      rd(8'h00, v); chk("R2 readback", v, d);
    end
    wr(8'h00, 8'h00);

    // R9 level sweep
    for (int i = 0; i < 32; i++) begin
      tx_slots = i[1:0]; rx_pending = i[2]; link_up = i[3]; speed_10m = i[4];
      rd(8'h01, v);
      chk("R9 levels", v, {i[4], i[3], 1'b0, i[2], (i[1:0] >= 2) ? 1'b1 : 1'b0, 3'b000});
    end
    tx_slots = '0; rx_pending = 0; link_up = 0; speed_10m = 0;

    // R5 / R6 sticky set and read clear
    for (int b = 0; b < 3; b++) begin
      int pos;
      pos = (b == 0) ? 1 : (b == 1) ? 2 : 0;
      pulse(4'(1 << b));
      rd(8'h01, v); chk("R5 sticky set", v, 1 << pos);
      rd(8'h01, v); chk("R6 read clears", v, 0);
    end
    // R7 write-1 clear, selective
    pulse(4'b0111);
    wr(8'h01, 8'h02);
    rd(8'h01, v); chk("R7 selective w1c", v, 8'h05);
    pulse(4'b0001);
    wr(8'h01, 8'h00);
    rd(8'h01, v); chk("R7 write0 no effect", v, 8'h02);
    // R7 event wins over write-1
    evs = 4'b0001; wr(8'h01, 8'h02); evs = '0;
    rd(8'h01, v); chk("R7 event wins", v, 8'h02);
    // R6 event wins over read
    evs = 4'b0001; rd(8'h01, v); evs = '0;
    rd(8'h01, v); chk("R6 event wins", v, 8'h02);

    // R8 wake
    pulse(4'b1000);
    rd(8'h01, v); chk("R8 disabled no set", v, 0);
    wr(8'h00, 8'h20);
    pulse(4'b1000);
    rd(8'h01, v); chk("R8 wake set", v, 8'h20);
    pulse(4'b1000);
    wr(8'h00, 8'h00);
    rd(8'h01, v); chk("R8 disable clears", v, 0);
    wr(8'h00, 8'h20);
    pulse(4'b1000);
    wr(8'h01, 8'h20);
    rd(8'h01, v); chk("R7 wake w1c", v, 0);

    // R10 duplex
    wr(8'h00, 8'h00);
    fdx_in = 1'b1; @(negedge clk);
    chk("R10 internal follows", fdx, 1);
    rd(8'h00, v); chk("R10 internal read", v, 8'h80);
    wr(8'h00, 8'h80);
    fdx_in = 1'b0; @(negedge clk);
    chk("R10 internal write ignored", fdx, 0);
    wr(8'h00, 8'h40);
    chk("R10 external reg default", fdx, 0);
    wr(8'h00, 8'hC0);
    chk("R10 external written", fdx, 1);
    rd(8'h00, v); chk("R10 external read", v, 8'hC0);

    // R3 / R4 soft reset
    wr(8'h00, 8'hEE);
    pulse(4'b1001);
    wr(8'h00, 8'hEF);
    n = 0;
    while (soft_rst) begin
      n++;
      if ({lpbk_mode, force_col, fdx} != 0)
        chk("R4 held during reset", {lpbk_mode, force_col, fdx}, 0);
      if (n == 100) wr(8'h00, 8'hEF);
      else if (n == 200) begin
        rd(8'h00, v); chk("R4 ctrl during reset", v, 8'h61);
      end
      else if (n == 300) pulse(4'b0001);
      else @(negedge clk);
    end
    chk("R3 soft reset length", n, SRST_LEN);
    rd(8'h01, v); chk("R4 wake kept, tx flag cleared", v, 8'h20);
    rd(8'h00, v); chk("R4 exempt bits kept", v, 8'h60);

    // R11 reserved and unmapped
    wr(8'h00, 8'h10);
    rd(8'h00, v); chk("R11 reserved bit", v, 8'h00);
    wr(8'h05, 8'hFF);
    chk("R11 unmapped write", {soft_rst, lpbk_mode, force_col, ext_phy_sel, wake_en}, 0);
    rd(8'h05, v); chk("R11 unmapped read", v, 0);
    rd(8'h01, v); chk("R11 status untouched", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule